// File: doc/BRIEF.md
# Tuner control serial slave

This block is the two-wire serial slave that programs a frequency synthesizer and reports its state. A controller addresses it with a 7-bit address. The upper five bits of that address are fixed. The lower two come from strap inputs, so up to four of these blocks can share one bus. In a write transfer the block takes four kinds of data byte: a divider-high byte, a divider-low byte, a control byte and a port byte. The MSB of the first data byte after the address selects where the transfer starts. From there the byte kinds advance by themselves until STOP.

The divider settings (the 17-bit ratio, the prescaler enable and the reference select) are assembled in a staging copy. They reach the outputs only on defined sequences or when the transfer ends. The port byte fields take effect as soon as that byte arrives. In a read transfer the block returns a status byte made of a power-on flag, the lock flag, three port input levels and a 3-bit converter code. It keeps sending while the controller acknowledges. SCL and SDA are sampled with the system clock. SDA is driven as an open-drain pull-down.

Top module: `tuner_ctrl_i2c`

## Requirements
- R1: An address byte is acknowledged (SDA pulled low during the ninth clock) only when its bits 7..3 equal 11000 and its bits 2..1 equal `strap[1:0]`. Bit 0 selects a read (1) or a write (0).
- R2: In a write, the first data byte is a divider-high byte {0, N14..N8} when its MSB is 0, and a control byte {1, N16, N15, PE, R3..R0} when its MSB is 1. A divider-low byte {N7..N0} always follows a divider-high byte, and a port byte always follows a control byte. After a divider-low byte or a port byte, the MSB of the next byte again picks its kind. Every data byte of an addressed write is acknowledged.
- R3: When all four byte kinds have arrived within one transfer, in either order, `div_ratio`, `presc_en` and `ref_sel` take the staged values at once, without waiting for STOP.
- R4: A STOP or repeated START commits the staged divider settings if the transfer contained a divider-high or control byte. Sending divider-high and divider-low bytes over and over without ending the transfer leaves `div_ratio` unchanged.
- R5: A port byte updates its fields at once: `cp_cur` = bits 7..6, `xt_en` = bit 5, `xt_sel` = bit 4, port bits = bits 3..0. No other event changes these fields.
- R6: Test mode is `xt_en`=0 with `xt_sel`=1. In test mode, `port_drv` = {bit3, 000} and `test_sel` = port bits 2..0. Otherwise `port_drv` = port bits 3..0.
- R7: After reset, `cp_cur`=00, `xt_en`=0, `xt_sel`=1, port bits=0100, `test_sel`=100, `port_drv`=0000, and `div_ratio`, `presc_en` and `ref_sel` are zero.
- R8: A read returns the status byte {POR, lock, port_in[2:0], adc_code[2:0]}, MSB first. It is captured when the byte starts, so inputs that change during a byte appear only in the next byte.
- R9: A controller acknowledge after a status byte starts another status byte. A non-acknowledge makes the block release SDA.
- R10: The POR flag is 1 after reset and clears when a read ends with a non-acknowledge. Only reset sets it again.
- R11: After an address that does not match, the block acknowledges nothing and ignores the following bytes until the next START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| scl | input | 1 | Serial clock line level |
| sda | input | 1 | Serial data line level |
| strap | input | 2 | Address strap bits |
| lock | input | 1 | Loop lock flag |
| port_in | input | 3 | Port input levels, bit 2 first in status |
| adc_code | input | 3 | Converter code |
| div_ratio | output | 17 | Committed main divider ratio |
| presc_en | output | 1 | Committed prescaler enable |
| ref_sel | output | 4 | Committed reference divider select |
| cp_cur | output | 2 | Charge pump current select |
| xt_en | output | 1 | Reference output enable |
| xt_sel | output | 1 | Reference output select / test enable |
| test_sel | output | 3 | Test mode select |
| port_drv | output | 4 | Port output drive (1 = on) |
| sda_pull | output | 1 | Open-drain SDA pull-down |

## Verification
The bench sweeps all sixteen pairs of strap value and address. A design that compared the wrong bits would acknowledge another device's address or stay silent on its own. It checks the divider outputs just before STOP and again just after, for the in-order and the swapped four-byte sequences, for repeated divider bytes and for single-byte transfers. Committing too early, committing too late or dropping the staged high bits each shows up as a wrong ratio. Read transfers sweep all converter codes and change the inputs between two acknowledged bytes, which exposes a status byte that is not captured once per byte or a POR flag that clears at the wrong moment. The test-mode port masking and the behaviour after a non-matching address are observed directly on the outputs.

// File: rtl/tsyn_pkg.sv
package tsyn_pkg;

    localparam int BYTE_W   = 8;
    localparam int DIV_W    = 17;
    localparam int REF_W    = 4;
    localparam int CP_W     = 2;
    localparam int PORT_W   = 4;
    localparam int STRAP_W  = 2;
    localparam logic [4:0] ADDR_FIXED = 5'b11000;

    typedef enum logic [2:0] {
        BS_IDLE, BS_RX, BS_RDONE, BS_RACK, BS_TX, BS_TACK, BS_WAIT
    } bus_st_e;

    typedef enum logic [1:0] {
        BK_DIVH = 2'd0, BK_DIVL = 2'd1, BK_CTRL = 2'd2, BK_PORT = 2'd3
    } byte_kind_e;

    typedef struct packed {
        logic [DIV_W-1:0] n;
        logic             pe;
        logic [REF_W-1:0] rsel;
    } div_cfg_t;

    typedef struct packed {
        logic [CP_W-1:0]   cp;
        logic              xce;
        logic              xcs;
        logic [PORT_W-1:0] pb;
    } port_cfg_t;

    localparam port_cfg_t PORT_RESET = '{cp: '0, xce: 1'b0, xcs: 1'b1, pb: 4'b0100};

    function automatic logic addr_match(input logic [BYTE_W-1:0] b,
                                        input logic [STRAP_W-1:0] s);
        return (b[7:3] == ADDR_FIXED) && (b[2:1] == s);
    endfunction

    function automatic byte_kind_e lead_kind(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1] ? BK_CTRL : BK_DIVH;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic scl_p, sda_p, scl_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[STAGES-2:0], sda_in};
            scl_p  <= scl_ff[STAGES-1];
            sda_p  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s    = scl_ff[STAGES-1];
    assign sda_s    = sda_ff[STAGES-1];
    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_bus_fsm.sv
module i2c_bus_fsm import tsyn_pkg::*; (
    input  logic               clk,
    input  logic               rst,
    input  logic               sda_s,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_ev,
    input  logic               stop_ev,
    input  logic [STRAP_W-1:0] strap,
    input  logic [BYTE_W-1:0]  status_in,
    output logic               wr_valid,
    output logic [BYTE_W-1:0]  wr_byte,
    output logic               wr_first,
    output logic               rd_done,
    output logic               sda_pull
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    bus_st_e           st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic              is_addr, rd_mode, acked, mack, first_data;
    logic [BYTE_W-1:0] rx_byte;

    assign rx_byte = {sh[BYTE_W-2:0], sda_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= BS_IDLE;
            cnt        <= '0;
            sh         <= '0;
            is_addr    <= 1'b0;
            rd_mode    <= 1'b0;
            acked      <= 1'b0;
            mack       <= 1'b0;
            first_data <= 1'b0;
            wr_valid   <= 1'b0;
            wr_byte    <= '0;
            wr_first   <= 1'b0;
            rd_done    <= 1'b0;
        end else begin
            wr_valid <= 1'b0;
            rd_done  <= 1'b0;
            if (start_ev) begin
                st         <= BS_RX;
                cnt        <= '0;
                is_addr    <= 1'b1;
                first_data <= 1'b0;
            end else if (stop_ev) begin
                st <= BS_IDLE;
            end else begin
                case (st)
                    BS_RX: if (scl_rise) begin
                        sh  <= rx_byte;
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_LAST) begin
                            st <= BS_RDONE;
                            if (is_addr) begin
                                acked   <= addr_match(rx_byte, strap);
                                rd_mode <= rx_byte[0];
                            end else begin
                                acked      <= 1'b1;
                                wr_valid   <= 1'b1;
                                wr_byte    <= rx_byte;
                                wr_first   <= first_data;
                                first_data <= 1'b0;
                            end
                        end
                    end
                    BS_RDONE: if (scl_fall) st <= acked ? BS_RACK : BS_WAIT;
                    BS_RACK: if (scl_fall) begin
                        if (is_addr && rd_mode) begin
                            st  <= BS_TX;
                            sh  <= status_in;
                            cnt <= '0;
                        end else begin
                            st         <= BS_RX;
                            cnt        <= '0;
                            first_data <= is_addr;
                        end
                        is_addr <= 1'b0;
                    end
                    BS_TX: if (scl_fall) begin
                        if (cnt == CNT_LAST) begin
                            st <= BS_TACK;
                        end else begin
                            sh  <= {sh[BYTE_W-2:0], 1'b0};
                            cnt <= cnt + 1'b1;
                        end
                    end
                    BS_TACK: begin
                        if (scl_rise) mack <= ~sda_s;
                        if (scl_fall) begin
                            if (mack) begin
                                st  <= BS_TX;
                                sh  <= status_in;
                                cnt <= '0;
                            end else begin
                                st      <= BS_WAIT;
                                rd_done <= 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull = (st == BS_RACK) || ((st == BS_TX) && !sh[BYTE_W-1]);

    // R1: an address acknowledge only follows a byte that matched the straps
    p_ack_needs_match_r1: assert property (@(posedge clk) disable iff (rst)
        (st == BS_RACK && is_addr) |-> (sh[7:3] == ADDR_FIXED && sh[2:1] == strap));

    // R8: status bits are only shifted out in a read transfer
    p_tx_only_read_r8: assert property (@(posedge clk) disable iff (rst)
        (st == BS_TX) |-> rd_mode);

endmodule

// File: rtl/tsyn_cfg_regs.sv
module tsyn_cfg_regs import tsyn_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              wr_first,
    input  logic              xfer_end,
    output div_cfg_t          div_live,
    output port_cfg_t         port_cfg
);
    div_cfg_t   div_stage, stage_nx;
    byte_kind_e pend, kind;
    logic       decide;
    logic [3:0] got, got_nx;
    logic       commit;

    assign kind   = (wr_first || decide) ? lead_kind(wr_byte) : pend;
    assign got_nx = got | (4'b0001 << kind);
    assign commit = (wr_valid && (got_nx == 4'hF))
                 || (xfer_end && (got[BK_DIVH] || got[BK_CTRL]));

    always_comb begin
        stage_nx = div_stage;
        if (wr_valid) begin
            case (kind)
                BK_DIVH: stage_nx.n[14:8] = wr_byte[6:0];
                BK_DIVL: stage_nx.n[7:0]  = wr_byte;
                BK_CTRL: begin
                    stage_nx.n[DIV_W-1:15] = wr_byte[6:5];
                    stage_nx.pe            = wr_byte[4];
                    stage_nx.rsel          = wr_byte[REF_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_stage <= '0;
            div_live  <= '0;
            port_cfg  <= PORT_RESET;
            got       <= '0;
            pend      <= BK_DIVH;
            decide    <= 1'b1;
        end else begin
            if (wr_valid) begin
                div_stage <= stage_nx;
                got       <= (got_nx == 4'hF) ? 4'h0 : got_nx;
                case (kind)
                    BK_DIVH: begin pend <= BK_DIVL; decide <= 1'b0; end
                    BK_CTRL: begin pend <= BK_PORT; decide <= 1'b0; end
                    BK_PORT: begin
                        port_cfg <= port_cfg_t'(wr_byte);
                        decide   <= 1'b1;
                    end
                    default: decide <= 1'b1;
                endcase
            end
            if (xfer_end) begin
                got    <= '0;
                decide <= 1'b1;
            end
            if (commit) div_live <= stage_nx;
        end
    end

    // R4: the live divider settings move only on a commit
    p_div_commit_only_r4: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(div_live));

    // R5: port fields move only when a byte is written
    p_port_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> $stable(port_cfg));

endmodule

// File: rtl/tuner_ctrl_i2c.sv
module tuner_ctrl_i2c import tsyn_pkg::*; #(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl,
    input  logic               sda,
    input  logic [STRAP_W-1:0] strap,
    input  logic               lock,
    input  logic [2:0]         port_in,
    input  logic [2:0]         adc_code,
    output logic [DIV_W-1:0]   div_ratio,
    output logic               presc_en,
    output logic [REF_W-1:0]   ref_sel,
    output logic [CP_W-1:0]    cp_cur,
    output logic               xt_en,
    output logic               xt_sel,
    output logic [2:0]         test_sel,
    output logic [PORT_W-1:0]  port_drv,
    output logic               sda_pull
);
    logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic wr_valid, wr_first, rd_done, por_q, test_mode;
    logic [BYTE_W-1:0] wr_byte, status_in;
    div_cfg_t  div_live;
    port_cfg_t port_cfg;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    assign status_in = {por_q, lock, port_in, adc_code};

    i2c_bus_fsm u_fsm (
        .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
        .strap(strap), .status_in(status_in), .wr_valid(wr_valid),
        .wr_byte(wr_byte), .wr_first(wr_first), .rd_done(rd_done),
        .sda_pull(sda_pull)
    );

    tsyn_cfg_regs u_regs (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_byte(wr_byte),
        .wr_first(wr_first), .xfer_end(start_ev | stop_ev),
        .div_live(div_live), .port_cfg(port_cfg)
    );

    always_ff @(posedge clk) begin
        if (rst)          por_q <= 1'b1;
        else if (rd_done) por_q <= 1'b0;
    end

    assign div_ratio = div_live.n;
    assign presc_en  = div_live.pe;
    assign ref_sel   = div_live.rsel;
    assign cp_cur    = port_cfg.cp;
    assign xt_en     = port_cfg.xce;
    assign xt_sel    = port_cfg.xcs;
    assign test_sel  = port_cfg.pb[2:0];
    assign test_mode = ~port_cfg.xce & port_cfg.xcs;
    assign port_drv  = test_mode ? {port_cfg.pb[3], 3'b000} : port_cfg.pb;

    // R10: once cleared, the power-on flag stays clear
    p_por_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (!por_q && !rd_done) |=> !por_q);

endmodule

// File: tb/sim_tuner_ctrl_i2c.sv
module sim_tuner_ctrl_i2c;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic scl = 1'b1, m_pull = 1'b0;
    logic [1:0] strap = 2'd2;
    logic lock = 1'b0;
    logic [2:0] port_in = '0, adc_code = '0;
    logic sda_line;
    logic [16:0] div_ratio;
    logic presc_en, xt_en, xt_sel, sda_pull;
    logic [3:0] ref_sel, port_drv;
    logic [1:0] cp_cur;
    logic [2:0] test_sel;

    assign sda_line = ~(m_pull | sda_pull);

    tuner_ctrl_i2c u0 (
        .clk(clk), .rst(rst), .scl(scl), .sda(sda_line), .strap(strap),
        .lock(lock), .port_in(port_in), .adc_code(adc_code),
        .div_ratio(div_ratio), .presc_en(presc_en), .ref_sel(ref_sel),
        .cp_cur(cp_cur), .xt_en(xt_en), .xt_sel(xt_sel), .test_sel(test_sel),
        .port_drv(port_drv), .sda_pull(sda_pull)
    );

    int nchk = 0, nfail = 0;
    logic [16:0] e_n;
    logic e_pe;
    logic [3:0] e_r;
    localparam logic [7:0] AW = 8'hC4, AR = 8'hC5;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic hp;  repeat (20) @(negedge clk); endtask
    task automatic gap; repeat (5)  @(negedge clk); endtask

    task automatic m_start;
        m_pull = 0; hp; scl = 1; hp; m_pull = 1; hp; scl = 0; gap;
    endtask
    task automatic m_stop;
        m_pull = 1; hp; scl = 1; hp; m_pull = 0; hp;
    endtask
    task automatic m_bit(input logic b);
        m_pull = ~b; hp; scl = 1; hp; scl = 0; gap;
    endtask
    task automatic m_rdbit(output logic b);
        m_pull = 0; hp; scl = 1; repeat (10) @(negedge clk);
        b = sda_line; repeat (10) @(negedge clk); scl = 0; gap;
    endtask
    task automatic m_wbyte(input logic [7:0] d, output logic ack);
        logic nak;
        for (int i = 7; i >= 0; i--) m_bit(d[i]);
        m_rdbit(nak);
        ack = ~nak;
    endtask
    task automatic m_rbyte(output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin m_rdbit(b); d[i] = b; end
    endtask
    task automatic wb(input logic [7:0] d);
        logic a;
        m_wbyte(d, a);
        chk("R2 byte ack", {31'd0, a}, 32'd1);
    endtask

    function automatic logic [7:0] b2(input logic [16:0] n); return {1'b0, n[14:8]}; endfunction
    function automatic logic [7:0] b3(input logic [16:0] n); return n[7:0]; endfunction
    function automatic logic [7:0] b4(input logic [16:0] n, input logic pe, input logic [3:0] r);
        return {1'b1, n[16:15], pe, r};
    endfunction

    task automatic chk_div(input string tag);
        chk(tag, {15'd0, div_ratio}, {15'd0, e_n});
        chk(tag, {27'd0, presc_en, ref_sel}, {27'd0, e_pe, e_r});
    endtask

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual timeout expected completion");
        report;
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] d;
        logic [16:0] nn;
        repeat (4) @(negedge clk);
        rst = 0;
        repeat (4) @(negedge clk);

        // R7 reset state
        chk("R7 div", {15'd0, div_ratio}, 32'd0);
        chk("R7 pe/ref", {27'd0, presc_en, ref_sel}, 32'd0);
        chk("R7 cp/xce/xcs", {28'd0, cp_cur, xt_en, xt_sel}, 32'b0001);
        chk("R7 test_sel", {29'd0, test_sel}, 32'b100);
        chk("R7 port_drv", {28'd0, port_drv}, 32'd0);
        e_n = '0; e_pe = 0; e_r = '0;

        // R1 address sweep over all strap/address pairs
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            for (int ad = 0; ad < 4; ad++) begin
                m_start;
                m_wbyte({5'b11000, 2'(ad), 1'b0}, a);
                chk("R1 addr ack", {31'd0, a}, {31'd0, (ad == s)});
                m_stop;
            end
        end
        strap = 2'd2;

        // R11 non-matching address: data ignored
        m_start;
        m_wbyte(8'hC0, a);
        chk("R11 no addr ack", {31'd0, a}, 32'd0);
        m_wbyte(8'hFF, a);
        chk("R11 no data ack", {31'd0, a}, 32'd0);
        m_wbyte(8'h00, a);
        m_stop;
        chk("R11 port unchanged", {28'd0, cp_cur, xt_en, xt_sel}, 32'b0001);
        chk_div("R11 div unchanged");

        // R2 R3 in-order full write, committed before STOP
        nn = 17'h15A3C;
        m_start; wb(AW);
        wb(b2(nn)); wb(b3(nn)); wb(b4(nn, 1'b1, 4'hA));
        chk("R3 no commit after three", {15'd0, div_ratio}, 32'd0);
        wb({2'b10, 1'b1, 1'b0, 4'b1011});
        e_n = nn; e_pe = 1; e_r = 4'hA;
        chk_div("R3 commit in order");
        chk("R5 port fields", {28'd0, cp_cur, xt_en, xt_sel}, 32'b1010);
        chk("R6 port_drv normal", {28'd0, port_drv}, 32'b1011);
        m_stop;
        chk_div("R3 after stop");

        // R4 repeated divider bytes without end do not commit
        nn = 17'h0ABCD;
        m_start; wb(AW);
        wb(b2(17'h01111)); wb(b3(17'h01111));
        wb(b2(nn)); wb(b3(nn));
        chk_div("R4 no commit before stop");
        m_stop;
        e_n = {e_n[16:15], nn[14:0]};
        chk_div("R4 commit on stop");

        // R3 swapped order: control, port, high, low
        nn = 17'h1F00F;
        m_start; wb(AW);
        wb(b4(nn, 1'b0, 4'h3)); wb({2'b01, 1'b1, 1'b1, 4'b0110});
        wb(b2(nn));
        chk("R3 no early commit", {15'd0, div_ratio}, {15'd0, e_n});
        wb(b3(nn));
        e_n = nn; e_pe = 0; e_r = 4'h3;
        chk_div("R3 commit swapped");
        m_stop;

        // R4 high byte alone then STOP
        m_start; wb(AW); wb(8'h2A); m_stop;
        e_n = {e_n[16:15], 7'h2A, e_n[7:0]};
        chk_div("R4 high then stop");

        // R4 control byte alone then STOP
        m_start; wb(AW); wb(b4(17'h08000, 1'b1, 4'h7)); m_stop;
        e_n = {2'b01, e_n[14:0]}; e_pe = 1; e_r = 4'h7;
        chk_div("R4 control then stop");

        // R4 repeated START ends the transfer
        m_start; wb(AW); wb(8'h11);
        m_start;
        e_n = {e_n[16:15], 7'h11, e_n[7:0]};
        chk_div("R4 repeated start commit");
        wb(AW); m_stop;

        // R6 test mode masks low ports
        m_start; wb(AW); wb(b4(e_n, e_pe, e_r)); wb({2'b11, 1'b0, 1'b1, 4'b1110}); m_stop;
        chk("R6 test port_drv", {28'd0, port_drv}, 32'b1000);
        chk("R6 test_sel", {29'd0, test_sel}, 32'b110);
        m_start; wb(AW); wb(b4(e_n, e_pe, e_r)); wb({2'b00, 1'b0, 1'b0, 4'b0111}); m_stop;
        chk("R6 disabled port_drv", {28'd0, port_drv}, 32'b0111);

        // R8 R9 R10 two-byte read with inputs changed between bytes
        lock = 1; port_in = 3'b101; adc_code = 3'b011;
        m_start; wb(AR);
        m_rbyte(d);
        chk("R8 status first", {24'd0, d}, {24'd0, 1'b1, 1'b1, 3'b101, 3'b011});
        lock = 0; port_in = 3'b010; adc_code = 3'b110;
        m_bit(1'b0);
        m_rbyte(d);
        chk("R9 second byte", {24'd0, d}, {24'd0, 1'b1, 1'b0, 3'b010, 3'b110});
        m_bit(1'b1);
        chk("R9 released", {31'd0, sda_pull}, 32'd0);
        m_stop;

        // R8 R10 sweep of converter codes, POR now clear
        for (int c = 0; c < 8; c++) begin
            adc_code = 3'(c); port_in = ~3'(c); lock = c[0];
            m_start; wb(AR);
            m_rbyte(d);
            m_bit(1'b1);
            m_stop;
            chk("R10 R8 status sweep", {24'd0, d}, {24'd0, 1'b0, c[0], ~3'(c), 3'(c)});
        end

        report;
        $finish;
    end
endmodule